// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides whether one memory access may proceed, given a small table of protection entries. Each access arrives as a start address, a byte count, a requested permission mask (read, write, execute) and a privilege mode. Every entry supplies inclusive lower and upper byte bounds and a configuration byte. Three security control bits choose the policy: lockdown semantics, a deny-by-default whitelist for machine mode, and a bypass of the per-entry lock for the classic rules. Another unit computes the bounds and owns the register writes.

Entries are searched in index order. The first active entry that touches the access decides the result. If that entry covers only one end of the access, the access is refused. If it covers both ends, the entry's permissions are looked up, under either the classic rules or the lockdown table. If no entry touches the access, one of three default policies applies. The verdict and the granted mask are registered once and appear on the clock edge after the inputs are sampled.

Top module: `pmp_access_checker`

## Requirements
- R1: Among active entries, the lowest-indexed one that holds the first byte, the last byte or both decides the result. Entries with higher indices are then ignored. An entry is active when its mode field, configuration bits [4:3], is nonzero.
- R2: The last byte is address + size - 1, and a size of 0 counts as 1 byte. If the deciding entry holds exactly one of the first and last bytes, the result is deny with a granted mask of 000. A last byte that carries past the top of the address space lies outside every entry.
- R3: An entry whose mode field is zero never decides, even if its bounds cover the access.
- R4: Mask bits are bit0 read, bit1 write and bit2 execute. The configuration byte holds the same bits in [2:0] and the lock bit in bit7. With lockdown off, a matched entry grants 111 to machine mode when that entry is unlocked. An entry is unlocked when its lock bit is clear or the lock-bypass input is high. In all other cases the grant is the entry's bits [2:0].
- R5: With lockdown on, the grant to machine mode from the code {lock,R,W,X} is as follows. Codes 0010 and 0011 give 011 (read and write). Code 1010 gives 100 (execute only). Code 1011 gives 101 (read and execute). Code 1111 gives 001 (read only). Any other locked code gives its own bits [2:0]. Any other unlocked code gives 000.
- R6: With lockdown on, the grant to a non-machine mode is as follows. Code 0010 gives 001 (read only). Code 0011 gives 011 (read and write). Codes 1010 and 1011 give 100 (execute only). Code 1111 gives 001 (read only). Any other unlocked code gives its own bits [2:0]. Any other locked code gives 000.
- R7: If no entry decides and the whitelist bit is set, the result is deny with a grant of 000. This applies regardless of mode and of the lockdown bit.
- R8: If no entry decides, the whitelist bit is clear and lockdown is on, a machine-mode access with no execute request is allowed with a grant of 011. Every other access is denied with a grant of 000.
- R9: If no entry decides and neither policy bit is set, machine mode is allowed with a grant of 111. Other modes are denied with a grant of 000.
- R10: For a matched entry, the access is allowed only when every requested bit is present in the grant.
- R11: Mode value 3 is machine mode. Values 0 (user), 1 (supervisor) and 2 are all treated as non-machine.
- R12: Both outputs are registered and show the result for the inputs sampled at the previous rising clock edge. While reset is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Access length in bytes (0 treated as 1) |
| req_perm | input | 3 | Requested mask {X,W,R} |
| req_mode | input | 2 | Privilege mode, 3 = machine |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Packed inclusive lower bounds, entry 0 in the low bits |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Packed inclusive upper bounds |
| ent_cfg | input | NUM_ENTRIES*8 | Packed configuration bytes |
| sec_mml | input | 1 | Lockdown semantics enable |
| sec_mmwp | input | 1 | Deny-by-default whitelist for no-match accesses |
| sec_rlb | input | 1 | Ignore entry locks under the classic rules |
| chk_allow | output | 1 | Access permitted (registered) |
| chk_grant | output | 3 | Granted mask {X,W,R} (registered) |

## Verification
Every result is due exactly one rising edge after its inputs are applied: the search, the lookup and the default policy are combinational, and they feed a single output register. The bench changes inputs one time unit after a rising edge. It reads both outputs one time unit after the next rising edge, so each sample sees exactly one register update. The reset check samples while reset is still held low. An independent bench model, driven by each stimulus, predicts both outputs for that same edge.

// File: rtl/pmp_chk_pkg.sv
// Package: shared bit positions and encodings for the access permission checker.
// Assumes a configuration byte of {lock, 2'bx, mode[1:0], X, W, R}.
package pmp_chk_pkg;
    localparam int CFG_W      = 8;
    localparam int PERM_W     = 3;
    localparam int CFG_LOCK   = 7;
    localparam int CFG_MODE_H = 4;
    localparam int CFG_MODE_L = 3;
    localparam int PB_R       = 0;
    localparam int PB_W       = 1;
    localparam int PB_X       = 2;
    localparam logic [1:0] MODE_MACHINE = 2'd3;

    typedef logic [PERM_W-1:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_R    = 3'b001;
    localparam perm_t PERM_RW   = 3'b011;
    localparam perm_t PERM_X    = 3'b100;
    localparam perm_t PERM_RX   = 3'b101;
    localparam perm_t PERM_RWX  = 3'b111;
endpackage

// File: rtl/pmp_entry_range.sv
// Module: per-entry bound test. Reports whether the first and the last byte of
// the access both lie inside [lo, hi] (full) or only one of them does (part).
// Assumes inclusive bounds; acc_last carries one extra bit so that an access
// running past the top of the address space is outside every entry.
module pmp_entry_range #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_first,
    input  logic [ADDR_W:0]   acc_last,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic [ADDR_W-1:0] bound_hi,
    input  logic              active,
    output logic              hit_full,
    output logic              hit_part
);
    logic first_in;
    logic last_in;

    // Compare both ends of the access against the inclusive bounds.
    always_comb begin
        first_in = (acc_first >= bound_lo) && (acc_first <= bound_hi);
        last_in  = (acc_last >= {1'b0, bound_lo}) && (acc_last <= {1'b0, bound_hi});
        hit_full = active && first_in && last_in;
        hit_part = active && (first_in ^ last_in);
    end
endmodule

// File: rtl/pmp_entry_perm.sv
// Module: per-entry permission lookup. Produces the mask this entry would grant
// under the classic rules or, with lockdown on, under the lockdown table.
// Assumes rwx is {X,W,R} and is_m marks machine mode.
module pmp_entry_perm
    import pmp_chk_pkg::*;
(
    input  logic  lock_bit,
    input  perm_t rwx,
    input  logic  is_m,
    input  logic  lockdown,
    input  logic  lock_bypass,
    output perm_t grant
);
    logic  shared_wo;
    logic  all_set;
    perm_t m_grant;
    perm_t su_grant;

    // Lockdown grants: shared codes first, then locked-to-M / unlocked-to-S/U.
    always_comb begin
        shared_wo = !rwx[PB_R] && rwx[PB_W];
        all_set   = lock_bit && (rwx == PERM_RWX);
        if (shared_wo) begin
            unique case ({lock_bit, rwx[PB_X]})
                2'b00:   begin m_grant = PERM_RW; su_grant = PERM_R;  end
                2'b01:   begin m_grant = PERM_RW; su_grant = PERM_RW; end
                2'b10:   begin m_grant = PERM_X;  su_grant = PERM_X;  end
                default: begin m_grant = PERM_RX; su_grant = PERM_X;  end
            endcase
        end else if (all_set) begin
            m_grant  = PERM_R;
            su_grant = PERM_R;
        end else if (lock_bit) begin
            m_grant  = rwx;
            su_grant = PERM_NONE;
        end else begin
            m_grant  = PERM_NONE;
            su_grant = rwx;
        end
    end

    // Pick the classic or lockdown result for the current mode.
    always_comb begin
        if (!lockdown) begin
            grant = (is_m && (!lock_bit || lock_bypass)) ? PERM_RWX : rwx;
        end else begin
            grant = is_m ? m_grant : su_grant;
        end
    end
endmodule

// File: rtl/pmp_prio_select.sv
// Module: fixed-priority pick of the lowest-indexed entry that touches the
// access. Reports whether that entry covers it fully or partly, and forwards
// that entry's grant and raw permission bits. Assumes packed vectors, entry 0
// in the low bits.
module pmp_prio_select
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic [NUM_ENTRIES-1:0]        hit_full,
    input  logic [NUM_ENTRIES-1:0]        hit_part,
    input  logic [NUM_ENTRIES*PERM_W-1:0] grant_vec,
    input  logic [NUM_ENTRIES*PERM_W-1:0] rwx_vec,
    output logic                          sel_full,
    output logic                          sel_part,
    output perm_t                         sel_grant,
    output perm_t                         sel_rwx
);
    // Walk from the top index down so the lowest touching entry wins.
    always_comb begin
        sel_full  = 1'b0;
        sel_part  = 1'b0;
        sel_grant = PERM_NONE;
        sel_rwx   = PERM_NONE;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_full[i] || hit_part[i]) begin
                sel_full  = hit_full[i];
                sel_part  = hit_part[i];
                sel_grant = grant_vec[i*PERM_W +: PERM_W];
                sel_rwx   = rwx_vec[i*PERM_W +: PERM_W];
            end
        end
    end
endmodule

// File: rtl/pmp_access_checker.sv
// Module: top of the access permission checker. Tests one access against all
// entries, resolves priority and partial overlap, applies the no-match default
// policy, and registers the verdict and granted mask for one cycle.
// Assumes bounds are precomputed by another unit; mode 3 is machine mode.
module pmp_access_checker
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [SIZE_W-1:0]             req_size,
    input  logic [PERM_W-1:0]             req_perm,
    input  logic [1:0]                    req_mode,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
    input  logic [NUM_ENTRIES*CFG_W-1:0]  ent_cfg,
    input  logic                          sec_mml,
    input  logic                          sec_mmwp,
    input  logic                          sec_rlb,
    output logic                          chk_allow,
    output logic [PERM_W-1:0]             chk_grant
);
    localparam int LAST_W = ADDR_W + 1;

    logic [SIZE_W-1:0]             size_eff;
    logic [LAST_W-1:0]             acc_last;
    logic                          is_m;
    logic [NUM_ENTRIES-1:0]        hit_full;
    logic [NUM_ENTRIES-1:0]        hit_part;
    logic [NUM_ENTRIES*PERM_W-1:0] grant_vec;
    logic [NUM_ENTRIES*PERM_W-1:0] rwx_vec;
    logic                          sel_full;
    logic                          sel_part;
    perm_t                         sel_grant;
    perm_t                         sel_rwx;
    logic                          nxt_allow;
    perm_t                         nxt_grant;
    logic                          unused_cfg;

    // Last byte address with one carry bit; zero length counts as one byte.
    always_comb begin
        size_eff = (req_size == '0) ? {{(SIZE_W-1){1'b0}}, 1'b1} : req_size;
        acc_last = {1'b0, req_addr} + {{(LAST_W-SIZE_W){1'b0}}, size_eff}
                   - {{(LAST_W-1){1'b0}}, 1'b1};
        is_m     = (req_mode == MODE_MACHINE);
    end

    assign unused_cfg = ^ent_cfg;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            logic [CFG_W-1:0] cfg_b;
            assign cfg_b = ent_cfg[g*CFG_W +: CFG_W];
            assign rwx_vec[g*PERM_W +: PERM_W] = cfg_b[PERM_W-1:0];

            pmp_entry_range #(.ADDR_W(ADDR_W)) u_range (
                .acc_first (req_addr),
                .acc_last  (acc_last),
                .bound_lo  (ent_lo[g*ADDR_W +: ADDR_W]),
                .bound_hi  (ent_hi[g*ADDR_W +: ADDR_W]),
                .active    (cfg_b[CFG_MODE_H:CFG_MODE_L] != 2'b00),
                .hit_full  (hit_full[g]),
                .hit_part  (hit_part[g])
            );

            pmp_entry_perm u_perm (
                .lock_bit    (cfg_b[CFG_LOCK]),
                .rwx         (cfg_b[PERM_W-1:0]),
                .is_m        (is_m),
                .lockdown    (sec_mml),
                .lock_bypass (sec_rlb),
                .grant       (grant_vec[g*PERM_W +: PERM_W])
            );
        end
    endgenerate

    pmp_prio_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_select (
        .hit_full  (hit_full),
        .hit_part  (hit_part),
        .grant_vec (grant_vec),
        .rwx_vec   (rwx_vec),
        .sel_full  (sel_full),
        .sel_part  (sel_part),
        .sel_grant (sel_grant),
        .sel_rwx   (sel_rwx)
    );

    // Verdict: partial denial, matched lookup, or the no-match default policy.
    always_comb begin
        if (sel_part) begin
            nxt_grant = PERM_NONE;
            nxt_allow = 1'b0;
        end else if (sel_full) begin
            nxt_grant = sel_grant;
            nxt_allow = ((req_perm & sel_grant) == req_perm);
        end else if (sec_mmwp) begin
            nxt_grant = PERM_NONE;
            nxt_allow = 1'b0;
        end else if (sec_mml) begin
            nxt_grant = (is_m && !req_perm[PB_X]) ? PERM_RW : PERM_NONE;
            nxt_allow = is_m && !req_perm[PB_X];
        end else begin
            nxt_grant = is_m ? PERM_RWX : PERM_NONE;
            nxt_allow = is_m;
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_allow <= 1'b0;
            chk_grant <= PERM_NONE;
        end else begin
            chk_allow <= nxt_allow;
            chk_grant <= nxt_grant;
        end
    end
endmodule

// File: rtl/pmp_access_checker_sva.sv
// Module: assertion checker for the access permission checker, bound to the top.
// Assumes it sees the selector's outputs and the registered results.
module pmp_access_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] req_perm,
    input logic [1:0] req_mode,
    input logic       sec_mml,
    input logic       sec_mmwp,
    input logic       sel_full,
    input logic       sel_part,
    input logic [2:0] sel_rwx,
    input logic       chk_allow,
    input logic [2:0] chk_grant
);
    // R12: reset clears both outputs one edge later.
    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!chk_allow && chk_grant == 3'b000));

    // R10: an allowed access never requests a bit outside the grant.
    a_r10_allow_subset: assert property (@(posedge clk) disable iff (!rst_n)
        chk_allow |-> (($past(req_perm) & chk_grant) == $past(req_perm)));

    // R2: partial cover from the selector becomes a registered denial.
    a_r2_partial_deny: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_part) |-> (!chk_allow && chk_grant == 3'b000));

    // R7: whitelist policy denies every unmatched access.
    a_r7_mmwp_deny: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_mmwp && !sel_full && !sel_part) |-> (!chk_allow && chk_grant == 3'b000));

    // R4: classic rules give non-machine modes exactly the entry bits.
    a_r4_classic_su: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_full && !sec_mml && req_mode != 2'd3) |-> (chk_grant == $past(sel_rwx)));
endmodule

bind pmp_access_checker pmp_access_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_perm  (req_perm),
    .req_mode  (req_mode),
    .sec_mml   (sec_mml),
    .sec_mmwp  (sec_mmwp),
    .sel_full  (sel_full),
    .sel_part  (sel_part),
    .sel_rwx   (sel_rwx),
    .chk_allow (chk_allow),
    .chk_grant (chk_grant)
);

// File: tb/pmp_access_checker_bench.sv
// Bench: directed corner cases plus seeded random accesses, each compared
// against a behavioural model of the requirements one edge after stimulus.
module pmp_access_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int AW = 32;
    localparam int SW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [SW-1:0]     req_size = '0;
    logic [2:0]        req_perm = '0;
    logic [1:0]        req_mode = '0;
    logic [NE*AW-1:0]  ent_lo;
    logic [NE*AW-1:0]  ent_hi;
    logic [NE*8-1:0]   ent_cfg;
    logic              sec_mml = 1'b0;
    logic              sec_mmwp = 1'b0;
    logic              sec_rlb = 1'b0;
    logic              chk_allow;
    logic [2:0]        chk_grant;

    logic [AW-1:0] lo_a [NE];
    logic [AW-1:0] hi_a [NE];
    logic [7:0]    cfg_a [NE];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    pmp_access_checker #(.NUM_ENTRIES(NE), .ADDR_W(AW), .SIZE_W(SW)) u_pmp_access_checker (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_size(req_size),
        .req_perm(req_perm), .req_mode(req_mode), .ent_lo(ent_lo), .ent_hi(ent_hi),
        .ent_cfg(ent_cfg), .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb),
        .chk_allow(chk_allow), .chk_grant(chk_grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            ent_lo[i*AW +: AW] = lo_a[i];
            ent_hi[i*AW +: AW] = hi_a[i];
            ent_cfg[i*8 +: 8]  = cfg_a[i];
        end
    end

    // Lockdown table from R5/R6: returns {machine grant, other grant}.
    function automatic logic [5:0] lockdown_tab(input logic [3:0] code);
        case (code)
            4'b0010: return {3'b011, 3'b001};
            4'b0011: return {3'b011, 3'b011};
            4'b1010: return {3'b100, 3'b100};
            4'b1011: return {3'b101, 3'b100};
            4'b1111: return {3'b001, 3'b001};
            default: begin
                logic [2:0] own;
                own = {code[0], code[1], code[2]};
                return code[3] ? {own, 3'b000} : {3'b000, own};
            end
        endcase
    endfunction

    // Behavioural model; tag names the requirement governing the result.
    function automatic void model(output logic allow, output logic [2:0] grant,
                                  output string tag);
        logic [AW:0] first_b, last_b;
        logic m;
        int sz;
        sz = (req_size == 0) ? 1 : int'(req_size);
        first_b = {1'b0, req_addr};
        last_b  = {1'b0, req_addr} + (AW+1)'(sz) - 1;
        m = (req_mode == 2'd3);
        for (int i = 0; i < NE; i++) begin
            if (cfg_a[i][4:3] != 0) begin
                bit fi, la;
                fi = (first_b >= {1'b0, lo_a[i]}) && (first_b <= {1'b0, hi_a[i]});
                la = (last_b  >= {1'b0, lo_a[i]}) && (last_b  <= {1'b0, hi_a[i]});
                if (fi != la) begin
                    allow = 0; grant = 0; tag = "R2"; return;
                end
                if (fi && la) begin
                    if (!sec_mml) begin
                        if (m && (!cfg_a[i][7] || sec_rlb)) grant = 3'b111;
                        else grant = cfg_a[i][2:0];
                        tag = "R4/R1";
                    end else begin
                        logic [5:0] t;
                        t = lockdown_tab({cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]});
                        grant = m ? t[5:3] : t[2:0];
                        tag = m ? "R5/R1" : "R6/R1";
                    end
                    allow = ((req_perm & grant) == req_perm);
                    return;
                end
            end
        end
        if (sec_mmwp) begin
            allow = 0; grant = 0; tag = "R7";
        end else if (sec_mml) begin
            allow = m && !req_perm[2]; grant = allow ? 3'b011 : 3'b000; tag = "R8";
        end else begin
            allow = m; grant = m ? 3'b111 : 3'b000; tag = "R9";
        end
    endfunction

    task automatic clear_entries();
        for (int i = 0; i < NE; i++) begin
            lo_a[i] = '0; hi_a[i] = '0; cfg_a[i] = 8'h00;
        end
    endtask

    // Apply current inputs, wait one edge, compare against the model.
    task automatic run_check(input string note);
        logic ea; logic [2:0] eg; string tag;
        model(ea, eg, tag);
        @(posedge clk); #1;
        n_checks++;
        if (chk_allow !== ea || chk_grant !== eg) begin
            n_fails++;
            $display("FAIL %s (%s): allow=%0b grant=%03b expected allow=%0b grant=%03b",
                     tag, note, chk_allow, chk_grant, ea, eg);
        end
    endtask

    task automatic set_req(input logic [AW-1:0] a, input int s, input logic [2:0] p,
                           input logic [1:0] md);
        req_addr = a; req_size = SW'(s); req_perm = p; req_mode = md;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h1A2B3C);
        clear_entries();
        set_req(32'h100, 4, 3'b111, 2'd3);
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (chk_allow !== 1'b0 || chk_grant !== 3'b000) begin
            n_fails++;
            $display("FAIL R12 reset: allow=%0b grant=%03b expected allow=0 grant=000",
                     chk_allow, chk_grant);
        end
        rst_n = 1'b1;

        // R9 / R11 defaults with no active entries.
        set_req(32'h40, 4, 3'b001, 2'd3); run_check("R9 machine default");
        set_req(32'h40, 4, 3'b001, 2'd1); run_check("R9 supervisor default");
        set_req(32'h40, 4, 3'b001, 2'd2); run_check("R11 mode 2 non-machine");
        // R8 lockdown defaults.
        sec_mml = 1;
        set_req(32'h40, 4, 3'b011, 2'd3); run_check("R8 machine rw");
        set_req(32'h40, 4, 3'b100, 2'd3); run_check("R8 machine exec");
        set_req(32'h40, 4, 3'b001, 2'd0); run_check("R8 user");
        // R7 whitelist.
        sec_mmwp = 1;
        set_req(32'h40, 4, 3'b001, 2'd3); run_check("R7 machine denied");
        sec_mmwp = 0; sec_mml = 0;

        // R1 priority: entry0 read-only inside entry1 rwx.
        lo_a[0] = 32'h100; hi_a[0] = 32'h1FF; cfg_a[0] = 8'h09;
        lo_a[1] = 32'h000; hi_a[1] = 32'h3FF; cfg_a[1] = 8'h0F;
        set_req(32'h150, 4, 3'b010, 2'd1); run_check("R1 lower entry wins");
        set_req(32'h300, 4, 3'b010, 2'd1); run_check("R1 fall to entry1");
        // R10 grant R but write requested -> denied, grant shown.
        set_req(32'h150, 4, 3'b011, 2'd0); run_check("R10 missing bit");
        // R2 straddle of entry0 upper edge.
        set_req(32'h1FC, 8, 3'b001, 2'd3); run_check("R2 straddle");
        set_req(32'h1FF, 0, 3'b001, 2'd1); run_check("R2 size zero one byte");
        // R3 OFF entry covering is skipped.
        cfg_a[0] = 8'h07;
        set_req(32'h150, 4, 3'b010, 2'd1); run_check("R3 off entry skipped");
        // R4 classic lock behaviour for machine mode.
        cfg_a[0] = 8'h09;
        set_req(32'h150, 4, 3'b100, 2'd3); run_check("R4 machine unlocked");
        cfg_a[0] = 8'h89;
        set_req(32'h150, 4, 3'b100, 2'd3); run_check("R4 machine locked");
        sec_rlb = 1;
        set_req(32'h150, 4, 3'b100, 2'd3); run_check("R4 lock bypass");
        sec_rlb = 0;
        // R2 wrap past top of address space.
        clear_entries();
        lo_a[0] = 32'hFFFF_FF00; hi_a[0] = 32'hFFFF_FFFF; cfg_a[0] = 8'h0F;
        set_req(32'hFFFF_FFFE, 4, 3'b001, 2'd3); run_check("R2 wrap");
        // R5 / R6 every lockdown code in both modes.
        sec_mml = 1;
        lo_a[0] = 32'h200; hi_a[0] = 32'h2FF;
        for (int c = 0; c < 16; c++) begin
            cfg_a[0] = {c[3], 2'b00, 2'b01, c[0], c[1], c[2]};
            set_req(32'h210, 4, 3'b001, 2'd3); run_check("R5 table");
            set_req(32'h210, 4, 3'b100, 2'd1); run_check("R6 table");
        end
        sec_mml = 0;

        // Seeded random mix.
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NE; i++) begin
                lo_a[i]  = ($urandom % 256) * 4;
                hi_a[i]  = lo_a[i] + ($urandom % 64);
                cfg_a[i] = 8'($urandom) & 8'h9F;
            end
            sec_mml  = ($urandom % 3) == 0;
            sec_mmwp = ($urandom % 4) == 0;
            sec_rlb  = ($urandom % 4) == 0;
            set_req($urandom % 32'h500, int'($urandom % 9), 3'($urandom % 8),
                    2'($urandom % 4));
            run_check("random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule